// File: doc/BRIEF.md
# Video Fetch Address Mapper

This block sits between a video controller and the memory system. Each fetch the controller issues carries a 2-bit bank number, which picks one of four 16 KB windows of the 64 KB RAM space, and a 14-bit offset inside that window. The mapper turns the fetch into a physical 16-bit RAM address and a source select. The select says whether RAM answers the fetch or whether the character ROM overlay answers it. The overlay exists only in banks 0 and 2, at window offsets $1000 to $1FFF. The CPU's memory banking configuration plays no part, so the block has no input for it.

Every beat also carries a 10-bit colour RAM address. The colour RAM sits on its own 4-bit data lines, so this address is produced on every fetch whatever the bank and whatever the source select. Memory contents and display timing lie outside the block.

Fetches enter on a valid/ready request port and leave through one register stage on a valid/ready response port. A request transfers on a cycle where `req_valid` and `req_ready` are both high. A response transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. `req_ready` is high whenever the stage is empty or its beat is leaving in the same cycle. While a response is stalled, its fields stay frozen and no new request is taken.

Top module: `vfm_top`

## Requirements
- R1: After reset, `rsp_valid` is low and `req_ready` is high.
- R2: `rsp_ram_addr` equals the request's bank number in bits 15:14 and the request offset in bits 13:0, for every bank.
- R3: `rsp_rom_sel` is 1 (character ROM) exactly when the bank is 0 or 2 and offset bits 13:12 equal 2'b01; otherwise it is 0 (RAM).
- R4: For banks 1 and 3, offsets $1000 to $1FFF give `rsp_rom_sel` = 0.
- R5: `rsp_rom_addr` equals offset bits 11:0 on every beat.
- R6: `rsp_col_addr` equals offset bits 9:0 on every beat, whatever the bank and whatever `rsp_rom_sel`.
- R7: A request accepted at a clock edge is presented with `rsp_valid` high directly after that edge.
- R8: While `rsp_valid` is high and `rsp_ready` is low, all response fields hold and `req_ready` is low.
- R9: With `rsp_ready` held high, one request is accepted every cycle, and the responses leave in order.
- R10: Offsets $0FFF and $2000 in bank 0 give `rsp_rom_sel` = 0; offsets $1000 and $1FFF in bank 2 give 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Mapper can take the request |
| req_bank | input | 2 | Video bank number (16 KB window) |
| req_addr | input | 14 | Window-relative fetch offset |
| rsp_valid | output | 1 | Mapped beat present |
| rsp_ready | input | 1 | Consumer takes the beat |
| rsp_ram_addr | output | 16 | Physical RAM address |
| rsp_rom_sel | output | 1 | 1 = character ROM serves the fetch, 0 = RAM |
| rsp_rom_addr | output | 12 | Character ROM address |
| rsp_col_addr | output | 10 | Colour RAM address |

## Verification
A stalled beat can leave in the same cycle that a new fetch enters the stage. This is provoked by lowering `rsp_ready` while a ROM-overlay beat is held and a RAM fetch waits on the request port, then raising `rsp_ready`. The check expects `req_ready` to rise in that same cycle. After the next edge the response must show the waiting RAM fetch, with its own source select and colour address, and the old beat must be gone. The continuous stream test also puts overlay decode and colour address generation into the same beat, for every bank.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  // geometry of the video view of memory
  localparam int BANK_W = 2;               // bank number width
  localparam int OFS_W  = 14;              // offset inside a 16 KB window
  localparam int RAM_W  = BANK_W + OFS_W;  // physical RAM address
  localparam int ROM_W  = 12;              // character ROM address
  localparam int COL_W  = 10;              // colour RAM address
  localparam int NBANK  = 1 << BANK_W;
  localparam int TAG_W  = OFS_W - ROM_W;   // offset bits above the ROM window

  // one bit per bank: 1 where the character ROM overlay appears
  localparam logic [NBANK-1:0] ROM_BANKS = 4'b0101;
  // value of the upper offset bits that selects the overlay window
  localparam logic [TAG_W-1:0] ROM_TAG = 2'b01;

  typedef enum logic {SRC_RAM = 1'b0, SRC_CHROM = 1'b1} src_e;

  typedef struct packed {
    logic [RAM_W-1:0] ram_addr;
    src_e             src;
    logic [ROM_W-1:0] rom_addr;
    logic [COL_W-1:0] col_addr;
  } beat_t;
endpackage

// File: rtl/vfm_decode.sv
module vfm_decode
  import vfm_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  output beat_t             beat
);
  logic [NBANK-1:0] bank_onehot;
  logic             overlay_bank;
  logic             overlay_win;

  // one-hot bank decode, gated by the overlay mask
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_onehot[b] = (bank == BANK_W'(b)) && ROM_BANKS[b];
  end

  assign overlay_bank = |bank_onehot;
  assign overlay_win  = (ofs[OFS_W-1:ROM_W] == ROM_TAG);

  always_comb begin
    beat.ram_addr = {bank, ofs};
    beat.src      = (overlay_bank && overlay_win) ? SRC_CHROM : SRC_RAM;
    beat.rom_addr = ofs[ROM_W-1:0];
    beat.col_addr = ofs[COL_W-1:0];
  end

  // odd banks never see the overlay
  always_comb begin
    if (bank[0] === 1'b1)
      AST_ODD_BANK_RAM: assert (beat.src == SRC_RAM) else $error("odd bank decoded to ROM"); // R4
  end
endmodule

// File: rtl/vfm_stage.sv
module vfm_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

  AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R7

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R9
endmodule

// File: rtl/vfm_top.sv
module vfm_top
  import vfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [OFS_W-1:0]  req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RAM_W-1:0]  rsp_ram_addr,
  output logic              rsp_rom_sel,
  output logic [ROM_W-1:0]  rsp_rom_addr,
  output logic [COL_W-1:0]  rsp_col_addr
);
  localparam int BEAT_W = $bits(beat_t);

  beat_t             dec_beat;
  beat_t             out_beat;
  logic [BEAT_W-1:0] out_bits;

  vfm_decode u_decode (
    .bank (req_bank),
    .ofs  (req_addr),
    .beat (dec_beat)
  );

  vfm_stage #(.W(BEAT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (dec_beat),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (out_bits)
  );

  assign out_beat     = beat_t'(out_bits);
  assign rsp_ram_addr = out_beat.ram_addr;
  assign rsp_rom_sel  = (out_beat.src == SRC_CHROM);
  assign rsp_rom_addr = out_beat.rom_addr;
  assign rsp_col_addr = out_beat.col_addr;

  AST_ROM_EVEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_rom_sel |-> !rsp_ram_addr[OFS_W] && rsp_ram_addr[OFS_W-1:ROM_W] == ROM_TAG); // R3

  AST_ROM_ADDR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rom_addr == rsp_ram_addr[ROM_W-1:0]); // R5

  AST_COL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_col_addr == rsp_ram_addr[COL_W-1:0]); // R6
endmodule

// File: tb/vfm_top_tb.sv
module vfm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [13:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_ram_addr;
  logic        rsp_rom_sel;
  logic [11:0] rsp_rom_addr;
  logic [9:0]  rsp_col_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  vfm_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ram_addr(rsp_ram_addr), .rsp_rom_sel(rsp_rom_sel),
    .rsp_rom_addr(rsp_rom_addr), .rsp_col_addr(rsp_col_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_rom(input logic [1:0] b, input logic [13:0] a);
    return (b == 2'd0 || b == 2'd2) && a >= 14'h1000 && a <= 14'h1FFF;
  endfunction

  // compare the response fields against a given fetch
  task automatic check_beat(input logic [1:0] b, input logic [13:0] a, input string tag);
    logic [15:0] e_ram = {b, a};
    check(rsp_valid === 1'b1, {tag, " R7 valid"}, 32'(rsp_valid), 1);
    check(rsp_ram_addr === e_ram, {tag, " R2 ram_addr"}, 32'(rsp_ram_addr), 32'(e_ram));
    check(rsp_rom_sel === exp_rom(b, a), {tag, " R3 rom_sel"}, 32'(rsp_rom_sel), 32'(exp_rom(b, a)));
    check(rsp_rom_addr === a[11:0], {tag, " R5 rom_addr"}, 32'(rsp_rom_addr), 32'(a[11:0]));
    check(rsp_col_addr === a[9:0], {tag, " R6 col_addr"}, 32'(rsp_col_addr), 32'(a[9:0]));
  endtask

  // single fetch with the consumer ready; checked after the accepting edge
  task automatic one_fetch(input logic [1:0] b, input logic [13:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(b, a, tag);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    check(req_ready === 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
  endtask

  task automatic t_banks;
    for (int b = 0; b < 4; b++) begin
      one_fetch(2'(b), 14'h0123, "bank ram R2");
      one_fetch(2'(b), 14'h1A5F, "window R3 R4");
      one_fetch(2'(b), 14'h3FFF, "top R2");
    end
  endtask

  task automatic t_boundaries;
    one_fetch(2'd0, 14'h0FFF, "R10 below");
    one_fetch(2'd0, 14'h2000, "R10 above");
    one_fetch(2'd2, 14'h1000, "R10 low edge");
    one_fetch(2'd2, 14'h1FFF, "R10 high edge");
    one_fetch(2'd1, 14'h1000, "R4 bank1");
    one_fetch(2'd3, 14'h1FFF, "R4 bank3");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_bank = 2'd2; req_addr = 14'h1234;
    @(negedge clk);
    req_bank = 2'd1; req_addr = 14'h2ABC;
    for (int i = 0; i < 3; i++) begin
      check(req_ready === 1'b0, "R8 req_ready stalled", 32'(req_ready), 0);
      check_beat(2'd2, 14'h1234, "R8 hold");
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    #1;
    check(req_ready === 1'b1, "R8 ready on drain", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(2'd1, 14'h2ABC, "R9 swap");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 emptied", 32'(rsp_valid), 0);
  endtask

  task automatic t_stream;
    logic [1:0]  pb = '0;
    logic [13:0] pa = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(req_ready === 1'b1, "R9 ready streaming", 32'(req_ready), 1);
        check_beat(pb, pa, "R9 stream");
      end
      pb = 2'(i);
      pa = 14'(14'h0F80 + i * 14'h0160);
      req_valid = 1'b1; req_bank = pb; req_addr = pa;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(pb, pa, "R9 last");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    t_reset();
    t_banks();
    t_boundaries();
    t_backpressure();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule